// File: doc/BRIEF.md
# Paged Multi-Port Serial Management Slave

This block is the device-side end of a two-wire serial management link (clock MDC, bidirectional data MDIO) for a device with four ports. It samples the data line on every rising edge of the management clock, hunts for a run of ones followed by the start pattern, and then decodes a 2-bit opcode, a 5-bit device address and a 5-bit register address. On a read it takes over the line for the second turnaround bit and the 16 data bits. On a write it checks the turnaround pattern and then captures the 16 data bits.

Each port owns a 32-address register space. Most addresses are widened by a page selector kept in register 22. Addresses 30 and 31 use a second selector kept in register 29. The two selector registers themselves are never paged.

A port can widen the set of writes it accepts by telling itself to ignore the upper or lower group of device-address bits. With that, one write can update the same register on several ports at once. Reads always decode the full address, so only one port can ever answer a read. The register contents are generic storage. The pad tristate is formed outside the block from `mdio_o` and `mdio_oe`.

Top module: `mdio_paged_slave`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising MDC edge), mdio_oe is 0 and every register of every port, including registers 22 and 29, reads back as 0.
- R2: A frame is at least 32 ones, start bits 0 then 1, opcode (10 = read, 01 = write), 5 device address bits and 5 register bits, each MSB first. On a matched read, mdio_oe stays 0 while the first turnaround bit is on the line. It rises after the rising edge that samples that bit and drives 0 for the second turnaround bit. It then drives D15 down to D0, one bit per rising edge, and releases after the edge that samples D0.
- R3: A write frame whose turnaround bits are 1 then 0, followed by 16 data bits MSB first, stores that data in the addressed register of each accepting port. mdio_oe stays 0 for the whole write frame.
- R4: Port n (n = 0..3) answers at device address {phy_base_hi, n}. A read at any other address leaves mdio_oe at 0, and a write to any other address (with no ignore bits set) changes no register.
- R5: Register addresses 0 to 21 and 23 to 28 are stored per page. The page is the low 2 bits of register 22 (4 pages), so selector values that differ only in higher bits reach the same page. Different pages hold independent values.
- R6: Register addresses 30 and 31 take their page from the low 2 bits of register 29, independently of register 22.
- R7: Registers 22 and 29 are reached directly whatever page is selected, and they read back the full 16-bit value written.
- R8: When bit 15 of a port's own register 22 is set, that port accepts writes whatever device address bits [4:2] are. When bit 14 is set, it accepts writes whatever bits [1:0] are. The other address bits must still match.
- R9: A read is answered only by the port whose full 5-bit address matches, whatever the ignore bits in register 22 are.
- R10: A start pattern after fewer than 32 consecutive ones is ignored. A preamble longer than 32 ones is accepted.
- R11: A frame with opcode 00 or 11, or a write whose turnaround bits are not 1 then 0, changes no register, and the slave returns to hunting for the preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, sampled on rising mdc |
| mdio_i | input | 1 | Data line as seen at the pad |
| phy_base_hi | input | 3 | Strapped upper device address bits shared by the four ports |
| mdio_o | output | 1 | Value driven onto the data line while enabled |
| mdio_oe | output | 1 | Drive enable for the data line, high only during a matched read |

## Verification
The embedded properties check on every cycle that the line is driven only for a read frame whose upper address bits match the strap, that each drive burst opens with a 0 and lasts no longer than 17 bit times, that a write strobe never coincides with drive and always belongs to a write frame, and that the page selectors hold still when no write is presented. Everything that depends on which value lands where can only be shown by the bench's scenarios: page selection and aliasing, the split between the two selectors, broadcast acceptance per port, exact read decoding, and the dropping of short-preamble, bad-opcode and bad-turnaround frames. The bench writes a distinct value into every paged slot of every port and reads all of them back.

// File: rtl/mdio_pkg.sv
// Package: shared constants and types for the paged serial management slave.
// Assumes a register width of 16 and the 5-bit address fields of the frame.
package mdio_pkg;

    localparam int REG_W       = 16;
    localparam int ADDR_W      = 5;
    localparam int HDR_BITS    = 2 + 2 * ADDR_W;   // opcode + device + register
    localparam int PRE_ONES    = 32;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    localparam logic [ADDR_W-1:0] SEL_MAIN_ADDR = 5'd22;
    localparam logic [ADDR_W-1:0] SEL_AUX_ADDR  = 5'd29;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_START,
        RX_HDR,
        RX_TA1,
        RX_TA2,
        RX_WDATA,
        RX_RDATA
    } rx_state_e;

endpackage

// File: rtl/mdio_frame_rx.sv
// Module: frame engine of the management slave.
// Samples mdio_i on rising mdc, hunts for the preamble, shifts in the header,
// checks the write turnaround, collects write data and serialises read data.
// Assumes the caller resolves the read hit and read data combinationally from
// the header outputs, which stay stable from the header's last bit onward.
module mdio_frame_rx
    import mdio_pkg::*;
#(
    parameter int MIN_PREAMBLE = PRE_ONES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic              rd_hit,
    input  logic [REG_W-1:0]  rd_data,
    output logic [1:0]        hdr_op,
    output logic [ADDR_W-1:0] hdr_phy,
    output logic [ADDR_W-1:0] hdr_reg,
    output logic              wr_stb,
    output logic [REG_W-1:0]  wr_data,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int ONES_W = $clog2(MIN_PREAMBLE + 1);
    localparam int CNT_W  = $clog2(REG_W + 1);
    localparam int RUN_W  = $clog2(REG_W + 3);

    rx_state_e               state;
    logic [ONES_W-1:0]       ones_cnt;
    logic [CNT_W-1:0]        bit_cnt;
    logic [HDR_BITS-1:0]     hdr_sh;
    logic [REG_W-1:0]        dat_sh;
    logic [HDR_BITS-1:0]     hdr_next;

    assign hdr_next = {hdr_sh[HDR_BITS-2:0], mdio_i};
    assign hdr_op   = hdr_sh[HDR_BITS-1 -: 2];
    assign hdr_phy  = hdr_sh[2*ADDR_W-1 -: ADDR_W];
    assign hdr_reg  = hdr_sh[ADDR_W-1:0];
    assign wr_data  = dat_sh;

    // Frame state machine: preamble hunt, header, turnaround, data phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_HUNT;
            ones_cnt <= '0;
            bit_cnt  <= '0;
            hdr_sh   <= '0;
            dat_sh   <= '0;
            wr_stb   <= 1'b0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            case (state)
                RX_HUNT: begin
                    if (mdio_i) begin
                        if (ones_cnt != ONES_W'(MIN_PREAMBLE)) begin
                            ones_cnt <= ones_cnt + 1'b1;
                        end
                    end else begin
                        if (ones_cnt == ONES_W'(MIN_PREAMBLE)) begin
                            state <= RX_START;
                        end
                        ones_cnt <= '0;
                    end
                end
                RX_START: begin
                    if (mdio_i) begin
                        state   <= RX_HDR;
                        bit_cnt <= CNT_W'(HDR_BITS - 1);
                    end else begin
                        state <= RX_HUNT;
                    end
                end
                RX_HDR: begin
                    hdr_sh <= hdr_next;
                    if (bit_cnt == '0) begin
                        if (hdr_next[HDR_BITS-1 -: 2] == OP_READ ||
                            hdr_next[HDR_BITS-1 -: 2] == OP_WRITE) begin
                            state <= RX_TA1;
                        end else begin
                            state <= RX_HUNT;
                        end
                    end else begin
                        bit_cnt <= bit_cnt - 1'b1;
                    end
                end
                RX_TA1: begin
                    if (hdr_op == OP_READ) begin
                        if (rd_hit) begin
                            dat_sh  <= rd_data;
                            mdio_oe <= 1'b1;
                            mdio_o  <= 1'b0;
                            bit_cnt <= CNT_W'(REG_W);
                            state   <= RX_RDATA;
                        end else begin
                            state <= RX_HUNT;
                        end
                    end else if (mdio_i) begin
                        state <= RX_TA2;
                    end else begin
                        state <= RX_HUNT;
                    end
                end
                RX_TA2: begin
                    if (!mdio_i) begin
                        bit_cnt <= CNT_W'(REG_W - 1);
                        state   <= RX_WDATA;
                    end else begin
                        state <= RX_HUNT;
                    end
                end
                RX_WDATA: begin
                    dat_sh <= {dat_sh[REG_W-2:0], mdio_i};
                    if (bit_cnt == '0) begin
                        wr_stb <= 1'b1;
                        state  <= RX_HUNT;
                    end else begin
                        bit_cnt <= bit_cnt - 1'b1;
                    end
                end
                RX_RDATA: begin
                    if (bit_cnt == '0) begin
                        mdio_oe <= 1'b0;
                        mdio_o  <= 1'b0;
                        state   <= RX_HUNT;
                    end else begin
                        mdio_o  <= dat_sh[REG_W-1];
                        dat_sh  <= {dat_sh[REG_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt - 1'b1;
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end

    // Drive-burst length counter used only by the check below.
    logic [RUN_W-1:0] oe_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_run <= '0;
        end else if (mdio_oe) begin
            oe_run <= oe_run + 1'b1;
        end else begin
            oe_run <= '0;
        end
    end

    // R2: a drive burst opens with the turnaround 0 bit.
    p_ta_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R2: turnaround bit plus 16 data bits, never longer.
    p_burst_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        oe_run <= RUN_W'(REG_W + 1));

    // R3: a write strobe belongs to a write frame and never overlaps drive.
    p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (hdr_op == OP_WRITE && !mdio_oe));

endmodule

// File: rtl/mdio_port_regs.sv
// Module: register space of one port.
// Holds the two unpaged selector registers and the paged storage. Addresses
// 30 and 31 take their page from the auxiliary selector, all others from the
// main one; only the low page bits are used. NUM_PAGES must be a power of two
// and at least 2. Read data is combinational from the address.
module mdio_port_regs
    import mdio_pkg::*;
#(
    parameter int NUM_PAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              ign_hi,
    output logic              ign_lo
);

    localparam int PAGE_W  = $clog2(NUM_PAGES);
    localparam int NUM_REG = 1 << ADDR_W;

    logic [REG_W-1:0]  sel_main;
    logic [REG_W-1:0]  sel_aux;
    logic [REG_W-1:0]  mem [NUM_PAGES][NUM_REG];
    logic [PAGE_W-1:0] page_idx;
    logic              uses_aux;

    assign uses_aux = (addr == 5'd30) || (addr == 5'd31);
    assign page_idx = uses_aux ? sel_aux[PAGE_W-1:0] : sel_main[PAGE_W-1:0];
    assign ign_hi   = sel_main[15];
    assign ign_lo   = sel_main[14];

    // Register writes: selectors are direct, everything else goes to a page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_main <= '0;
            sel_aux  <= '0;
            for (int p = 0; p < NUM_PAGES; p++) begin
                for (int r = 0; r < NUM_REG; r++) begin
                    mem[p][r] <= '0;
                end
            end
        end else if (wr_en) begin
            if (addr == SEL_MAIN_ADDR) begin
                sel_main <= wdata;
            end else if (addr == SEL_AUX_ADDR) begin
                sel_aux <= wdata;
            end else begin
                mem[page_idx][addr] <= wdata;
            end
        end
    end

    // Read mux: selectors bypass the paged storage.
    always_comb begin
        if (addr == SEL_MAIN_ADDR) begin
            rdata = sel_main;
        end else if (addr == SEL_AUX_ADDR) begin
            rdata = sel_aux;
        end else begin
            rdata = mem[page_idx][addr];
        end
    end

    // R7: selectors only move when a write is presented.
    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(sel_main) && $stable(sel_aux)));

endmodule

// File: rtl/mdio_paged_slave.sv
// Module: top of the four-port paged serial management slave.
// Connects the frame engine to one register space per port. Port n answers
// at {phy_base_hi, n}. Writes honour each port's own ignore bits; reads
// always decode the full address. Assumes mdio_i is already synchronous to mdc.
module mdio_paged_slave
    import mdio_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int PORT_BITS = 2
) (
    input  logic                      mdc,
    input  logic                      rst_n,
    input  logic                      mdio_i,
    input  logic [ADDR_W-PORT_BITS-1:0] phy_base_hi,
    output logic                      mdio_o,
    output logic                      mdio_oe
);

    localparam int NUM_PORTS = 1 << PORT_BITS;

    logic [1:0]        hdr_op;
    logic [ADDR_W-1:0] hdr_phy;
    logic [ADDR_W-1:0] hdr_reg;
    logic              wr_stb;
    logic [REG_W-1:0]  wr_data;
    logic              rd_hit;
    logic [REG_W-1:0]  rd_data;
    logic [REG_W-1:0]  port_rdata [NUM_PORTS];
    logic [NUM_PORTS-1:0] port_ign_hi;
    logic [NUM_PORTS-1:0] port_ign_lo;
    logic [NUM_PORTS-1:0] port_wr_en;
    logic              hi_match;

    assign hi_match = (hdr_phy[ADDR_W-1:PORT_BITS] == phy_base_hi);
    assign rd_hit   = hi_match;
    assign rd_data  = port_rdata[hdr_phy[PORT_BITS-1:0]];

    mdio_frame_rx #(
        .MIN_PREAMBLE (PRE_ONES)
    ) u_rx (
        .clk     (mdc),
        .rst_n   (rst_n),
        .mdio_i  (mdio_i),
        .rd_hit  (rd_hit),
        .rd_data (rd_data),
        .hdr_op  (hdr_op),
        .hdr_phy (hdr_phy),
        .hdr_reg (hdr_reg),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port
        logic lo_match;

        // Write acceptance per port, using this port's own ignore bits.
        assign lo_match      = (hdr_phy[PORT_BITS-1:0] == PORT_BITS'(n));
        assign port_wr_en[n] = wr_stb && (port_ign_hi[n] || hi_match)
                                      && (port_ign_lo[n] || lo_match);

        mdio_port_regs #(
            .NUM_PAGES (NUM_PAGES)
        ) u_regs (
            .clk    (mdc),
            .rst_n  (rst_n),
            .wr_en  (port_wr_en[n]),
            .addr   (hdr_reg),
            .wdata  (wr_data),
            .rdata  (port_rdata[n]),
            .ign_hi (port_ign_hi[n]),
            .ign_lo (port_ign_lo[n])
        );
    end

    // R9: the line is driven only for a read whose upper address matches.
    p_read_decode_r9: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> (hdr_op == OP_READ && hdr_phy[ADDR_W-1:PORT_BITS] == phy_base_hi));

    // R4: no port is written outside a write strobe.
    p_wr_gated_r4: assert property (@(posedge mdc) disable iff (!rst_n)
        !wr_stb |-> (port_wr_en == '0));

endmodule

// File: tb/mdio_paged_slave_tb.sv
module mdio_paged_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] BASE = 3'b101;

    logic mdc = 1'b0;
    logic rst_n = 1'b0;
    logic mdio_i = 1'b1;
    logic mdio_o, mdio_oe;
    int   checks = 0;
    int   errors = 0;
    int   curpg [4];

    always #(CLK_PERIOD / 2) mdc = ~mdc;

    mdio_paged_slave u_dut (
        .mdc         (mdc),
        .rst_n       (rst_n),
        .mdio_i      (mdio_i),
        .phy_base_hi (BASE),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe)
    );

    function automatic logic [15:0] fval(int p, int pg, int r);
        return 16'(p * 4096 + pg * 512 + r * 16 + 5);
    endfunction

    function automatic logic [4:0] paddr(int p);
        return {BASE, 2'(p)};
    endfunction

    task automatic send_bit(input logic b);
        @(negedge mdc);
        mdio_i = b;
    endtask

    task automatic send_hdr(input int pre, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] ra);
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(op[1]);
        send_bit(op[0]);
        for (int i = 4; i >= 0; i--) send_bit(phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
    endtask

    task automatic wr(input logic [4:0] phy, input logic [4:0] ra,
                      input logic [15:0] d, input logic [1:0] ta = 2'b10,
                      input logic [1:0] op = 2'b01, input int pre = 32);
        send_hdr(pre, op, phy, ra);
        send_bit(ta[1]);
        send_bit(ta[0]);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic rd(input logic [4:0] phy, input logic [4:0] ra,
                      output logic [15:0] data, output logic ok, output logic drove);
        data  = '0;
        send_hdr(32, 2'b10, phy, ra);
        @(negedge mdc);
        ok    = !mdio_oe;
        mdio_i = 1'b1;
        @(negedge mdc);
        drove = mdio_oe;
        if (drove) begin
            ok = ok && (mdio_o == 1'b0);
            for (int i = 15; i >= 0; i--) begin
                @(negedge mdc);
                ok = ok && mdio_oe;
                data[i] = mdio_o;
            end
            @(negedge mdc);
            ok = ok && !mdio_oe;
        end else begin
            for (int i = 0; i < 17; i++) begin
                @(negedge mdc);
                if (mdio_oe) ok = 1'b0;
            end
        end
    endtask

    task automatic chk_read(input string req, input logic [4:0] phy,
                            input logic [4:0] ra, input logic [15:0] exp);
        logic [15:0] d;
        logic ok, drove;
        rd(phy, ra, d, ok, drove);
        checks++;
        if (!ok || !drove || d !== exp) begin
            errors++;
            $display("FAIL %s phy=%0d reg=%0d: got %h (drive=%0b timing=%0b) expected %h",
                     req, phy, ra, d, drove, ok, exp);
        end
    endtask

    task automatic chk_silent(input string req, input logic [4:0] phy, input logic [4:0] ra);
        logic [15:0] d;
        logic ok, drove;
        rd(phy, ra, d, ok, drove);
        checks++;
        if (drove || !ok) begin
            errors++;
            $display("FAIL %s phy=%0d reg=%0d: got drive=%0b expected drive=0",
                     req, phy, ra, drove);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge mdc);
        rst_n = 1'b1;
        @(negedge mdc);

        // R1: reset state.
        checks++;
        if (mdio_oe !== 1'b0) begin
            errors++;
            $display("FAIL R1 oe after reset: got %b expected 0", mdio_oe);
        end
        for (int p = 0; p < 4; p++) begin
            chk_read("R1", paddr(p), 5'd0, 16'h0);
            chk_read("R1", paddr(p), 5'd22, 16'h0);
            chk_read("R1", paddr(p), 5'd29, 16'h0);
            chk_read("R1", paddr(p), 5'd31, 16'h0);
        end

        // R3 R5 R6: fill every paged slot with a distinct value.
        for (int p = 0; p < 4; p++) begin
            for (int pg = 0; pg < 4; pg++) begin
                wr(paddr(p), 5'd22, 16'(pg));
                wr(paddr(p), 5'd29, 16'(pg));
                for (int r = 0; r < 32; r++) begin
                    if (r != 22 && r != 29) wr(paddr(p), 5'(r), fval(p, pg, r));
                end
            end
        end

        // R2 R5 R6 R7: read back with aliased selector values.
        for (int p = 0; p < 4; p++) begin
            for (int pg = 0; pg < 4; pg++) begin
                wr(paddr(p), 5'd22, 16'(pg + 8));
                wr(paddr(p), 5'd29, 16'(pg + 4));
                curpg[p] = pg;
                chk_read("R7", paddr(p), 5'd22, 16'(pg + 8));
                chk_read("R7", paddr(p), 5'd29, 16'(pg + 4));
                for (int r = 0; r < 32; r++) begin
                    if (r == 30 || r == 31)
                        chk_read("R6", paddr(p), 5'(r), fval(p, pg, r));
                    else if (r != 22 && r != 29)
                        chk_read("R5", paddr(p), 5'(r), fval(p, pg, r));
                end
            end
        end

        // R6: the two selectors pick pages independently.
        wr(paddr(2), 5'd22, 16'd1);
        wr(paddr(2), 5'd29, 16'd2);
        curpg[2] = 1;
        chk_read("R6", paddr(2), 5'd30, fval(2, 2, 30));
        chk_read("R6", paddr(2), 5'd31, fval(2, 2, 31));
        chk_read("R5", paddr(2), 5'd5, fval(2, 1, 5));

        // R4: unmatched addresses.
        chk_silent("R4", 5'd0, 5'd5);
        chk_silent("R4", 5'd24, 5'd5);
        wr(5'd24, 5'd5, 16'hDEAD);
        wr(5'd3, 5'd5, 16'hBEEF);
        for (int p = 0; p < 4; p++) chk_read("R4", paddr(p), 5'd5, fval(p, curpg[p], 5));

        // R11: bad opcodes and bad write turnaround.
        wr(paddr(1), 5'd5, 16'h1234, 2'b10, 2'b00);
        wr(paddr(1), 5'd5, 16'h2345, 2'b10, 2'b11);
        wr(paddr(1), 5'd5, 16'h3456, 2'b11, 2'b01);
        wr(paddr(1), 5'd5, 16'h4567, 2'b00, 2'b01);
        chk_read("R11", paddr(1), 5'd5, fval(1, 3, 5));

        // R10: short preamble is ignored, long preamble accepted.
        send_bit(1'b0);
        send_bit(1'b0);
        wr(paddr(1), 5'd5, 16'h4321, 2'b10, 2'b01, 31);
        chk_read("R10", paddr(1), 5'd5, fval(1, 3, 5));
        wr(paddr(1), 5'd6, 16'h0BEE, 2'b10, 2'b01, 40);
        chk_read("R10", paddr(1), 5'd6, 16'h0BEE);

        // R8: port 0 ignores the low address bits.
        wr(paddr(3), 5'd22, 16'h0000);
        wr(paddr(2), 5'd22, 16'h0000);
        wr(paddr(1), 5'd22, 16'h0000);
        wr(paddr(0), 5'd22, 16'h4000);
        wr(paddr(3), 5'd3, 16'hA5A5);
        chk_read("R8", paddr(0), 5'd3, 16'hA5A5);
        chk_read("R8", paddr(3), 5'd3, 16'hA5A5);
        chk_read("R8", paddr(1), 5'd3, fval(1, 0, 3));
        chk_read("R8", paddr(2), 5'd3, fval(2, 0, 3));
        // R9: port 0 does not answer reads for port 1's address.
        chk_read("R9", paddr(1), 5'd3, fval(1, 0, 3));
        chk_read("R7", paddr(0), 5'd22, 16'h4000);

        // R8: port 1 ignores the high address bits.
        wr(paddr(0), 5'd22, 16'h0000);
        wr(paddr(1), 5'd22, 16'h8000);
        wr(5'd1, 5'd4, 16'h5A5A);
        chk_read("R8", paddr(1), 5'd4, 16'h5A5A);
        chk_read("R8", paddr(0), 5'd4, fval(0, 0, 4));
        chk_silent("R9", 5'd1, 5'd4);

        // R8: port 2 ignores both groups.
        wr(paddr(2), 5'd22, 16'hC000);
        wr(5'd0, 5'd7, 16'h0F0F);
        chk_read("R8", paddr(2), 5'd7, 16'h0F0F);
        chk_read("R8", paddr(1), 5'd7, fval(1, 0, 7));
        chk_read("R8", paddr(0), 5'd7, fval(0, 0, 7));

        finish_run();
    end

endmodule